// File: doc/BRIEF.md
# Filter Selection Expander Write Translator

This block turns the filter-control settings of a receiver/transmitter into single-byte write requests for an 8-bit I2C port expander on a companion filter board. The byte to drive on the expander pins is computed each cycle from the current settings. The block asks a downstream I2C master for a write only when that byte differs from the byte most recently written.

There are two mapping modes. In standard mode, the seven open-collector bits drive the low seven expander pins, and the top pin carries the transmit indicator. In manual mode, the whole byte is a software-supplied receive pattern or transmit pattern, picked by the transmit state. Requests use a valid/ready handshake. A request holds steady until the master accepts it. Changes that arrive while a request is stalled fold into a single follow-up write carrying the latest byte.

Top module: `fsel_i2c_xlate`

The controller is a two-state machine:
- IDLE: no request is outstanding.
- SEND: a request is presented and waits for acceptance.

It has two transitions:
- IDLE to SEND on "byte differs": the computed byte is not equal to the last accepted byte.
- SEND to IDLE on "accepted": `req_ready` is high while `req_valid` is high.

## Requirements
- R1: After reset, `req_valid` is low. The block assumes the expander holds 0x00, so no request is made while the computed byte is 0x00.
- R2: Every request carries target address 0x20 on `req_addr` and the register index parameter (default 0x09) on `req_reg`.
- R3: In standard mode (`manual_mode` = 0), the byte is `{mox, oc_bits[6:0]}`. Bit 7 is 1 while transmitting and 0 while receiving.
- R4: In standard mode, changes to `rx_pat` and `tx_pat` produce no request.
- R5: In manual mode (`manual_mode` = 1), the byte is `rx_pat` while `mox` = 0 and `tx_pat` while `mox` = 1.
- R6: In manual mode, a `mox` transition whose selected pattern equals the last accepted byte produces no request.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_data` stays unchanged.
- R8: Changes made during a stalled request are not queued one by one. After acceptance, exactly one further request follows, and it carries the latest byte.
- R9: A request is raised only when the computed byte differs from the last accepted byte. Rewriting an identical value produces no request.
- R10: Switching between modes re-evaluates the byte under the new mapping. A request follows only if the result differs from the last accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mox | input | 1 | Transmit state (1 = transmit) |
| manual_mode | input | 1 | 1 = manual pattern mode, 0 = standard mode |
| oc_bits | input | 7 | Open-collector bits for standard mode |
| rx_pat | input | 8 | Manual-mode receive pattern |
| tx_pat | input | 8 | Manual-mode transmit pattern |
| req_ready | input | 1 | I2C master accepts the request |
| req_valid | output | 1 | Write request outstanding |
| req_addr | output | 7 | 7-bit I2C target address |
| req_reg | output | 8 | Expander register index |
| req_data | output | 8 | Byte to write |

## Verification
The bench stalls the master while the settings change twice. A design that queued every change would emit a stale intermediate write, and one that sampled live inputs would corrupt the held byte. It toggles transmit in manual mode with equal patterns, rewrites an unchanged open-collector value, and returns to standard mode with an identical resulting byte. A design without duplicate suppression would issue needless writes in each of these cases. It also changes the manual patterns while in standard mode, where a wrong mapping would leak pattern bits onto the expander.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned I2C_AW    = 7;
    localparam int unsigned OC_W      = BYTE_W - 1;

    localparam logic [I2C_AW-1:0] EXP_ADDR  = 7'h20;
    localparam logic [BYTE_W-1:0] EXP_RESET = 8'h00;

    typedef logic [BYTE_W-1:0] exp_byte_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } req_state_e;

endpackage

// File: rtl/fsel_byte_map.sv
module fsel_byte_map
    import fsel_pkg::*;
(
    input  logic              mox,
    input  logic              manual_mode,
    input  logic [OC_W-1:0]   oc_bits,
    input  exp_byte_t         rx_pat,
    input  exp_byte_t         tx_pat,
    output exp_byte_t         want
);

    exp_byte_t std_byte;
    exp_byte_t man_byte;

    // standard: transmit flag on the top pin, open-collector bits below
    always_comb begin
        std_byte = {mox, oc_bits};
    end

    // manual: whole byte from the pattern that matches the current direction
    always_comb begin
        man_byte = mox ? tx_pat : rx_pat;
    end

    always_comb begin
        want = manual_mode ? man_byte : std_byte;
    end

endmodule

// File: rtl/fsel_req_fsm.sv
module fsel_req_fsm
    import fsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  exp_byte_t  want,
    input  logic       ready,
    output logic       valid,
    output exp_byte_t  data
);

    req_state_e state_q;
    req_state_e state_d;
    exp_byte_t  last_q;
    exp_byte_t  data_q;
    logic       differs;
    logic       accept;

    assign differs = (want != last_q);
    assign accept  = (state_q == ST_SEND) && ready;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (differs) state_d = ST_SEND;
            ST_SEND: if (ready)   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers: the held byte and the last accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= EXP_RESET;
            last_q <= EXP_RESET;
        end else begin
            if (state_q == ST_IDLE && differs) data_q <= want;
            if (accept)                        last_q <= data_q;
        end
    end

    // outputs
    always_comb begin
        valid = (state_q == ST_SEND);
        data  = data_q;
    end

endmodule

// File: rtl/fsel_i2c_xlate.sv
module fsel_i2c_xlate
    import fsel_pkg::*;
#(
    parameter logic [7:0] REG_IDX = 8'h09
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mox,
    input  logic        manual_mode,
    input  logic [6:0]  oc_bits,
    input  logic [7:0]  rx_pat,
    input  logic [7:0]  tx_pat,
    input  logic        req_ready,
    output logic        req_valid,
    output logic [6:0]  req_addr,
    output logic [7:0]  req_reg,
    output logic [7:0]  req_data
);

    exp_byte_t want;

    fsel_byte_map u_map (
        .mox         (mox),
        .manual_mode (manual_mode),
        .oc_bits     (oc_bits),
        .rx_pat      (rx_pat),
        .tx_pat      (tx_pat),
        .want        (want)
    );

    fsel_req_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (want),
        .ready (req_ready),
        .valid (req_valid),
        .data  (req_data)
    );

    assign req_addr = EXP_ADDR;
    assign req_reg  = REG_IDX;

endmodule

// File: rtl/fsel_i2c_xlate_chk.sv
module fsel_i2c_xlate_chk #(
    parameter logic [7:0] REG_IDX = 8'h09
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       req_valid,
    input logic [6:0] req_addr,
    input logic [7:0] req_reg,
    input logic [7:0] req_data
);

    logic       seen_q;
    logic [7:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            acc_q  <= 8'h00;
        end else begin
            seen_q <= 1'b1;
            if (req_valid && req_ready) acc_q <= req_data;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !req_valid);

    a_r2_target: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr == 7'h20 && req_reg == REG_IDX));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data)));

    a_r9_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_data != acc_q));

endmodule

bind fsel_i2c_xlate fsel_i2c_xlate_chk #(.REG_IDX(REG_IDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_reg   (req_reg),
    .req_data  (req_data)
);

// File: tb/fsel_i2c_xlate_bench.sv
module fsel_i2c_xlate_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mox = 1'b0;
    logic       manual_mode = 1'b0;
    logic [6:0] oc_bits = 7'h00;
    logic [7:0] rx_pat = 8'h00;
    logic [7:0] tx_pat = 8'h00;
    logic       req_ready = 1'b0;
    logic       req_valid;
    logic [6:0] req_addr;
    logic [7:0] req_reg;
    logic [7:0] req_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    fsel_i2c_xlate u_fsel_i2c_xlate (
        .clk(clk), .rst_n(rst_n), .mox(mox), .manual_mode(manual_mode),
        .oc_bits(oc_bits), .rx_pat(rx_pat), .tx_pat(tx_pat),
        .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
        .req_reg(req_reg), .req_data(req_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<50000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // wait for a request, check it, accept it
    task automatic expect_req(input logic [7:0] exp, input string tag);
        int n = 0;
        while (!req_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(req_valid, {tag, " valid"}, req_valid, 1);
        check(req_data == exp, {tag, " data"}, req_data, exp);
        check(req_addr == 7'h20 && req_reg == 8'h09, "R2 addr/index",
              {req_addr, req_reg}, {7'h20, 8'h09});
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic expect_none(input int cycles, input string tag);
        bit hit = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (req_valid) hit = 1;
        end
        check(!hit, tag, hit, 0);
    endtask

    task automatic t_reset;
        expect_none(5, "R1 no request after reset");
    endtask

    task automatic t_standard;
        oc_bits = 7'h15;
        expect_req(8'h15, "R3 std rx");
        mox = 1'b1;
        expect_req(8'h95, "R3 std tx flag");
        rx_pat = 8'hAA; tx_pat = 8'h5C;
        expect_none(5, "R4 patterns ignored in standard");
        oc_bits = 7'h15;
        expect_none(5, "R9 same oc value");
    endtask

    task automatic t_manual;
        tx_pat = 8'h3C;
        manual_mode = 1'b1;
        expect_req(8'h3C, "R10 enter manual tx");
        rx_pat = 8'hA1;
        mox = 1'b0;
        expect_req(8'hA1, "R5 manual rx");
        mox = 1'b1;
        expect_req(8'h3C, "R5 manual tx");
        rx_pat = 8'h55; tx_pat = 8'h55;
        expect_req(8'h55, "R5 manual tx update");
        mox = 1'b0;
        expect_none(5, "R6 toggle equal patterns");
        mox = 1'b1;
        expect_none(5, "R6 toggle back");
    endtask

    task automatic t_mode_back;
        oc_bits = 7'h55;
        mox = 1'b0;
        manual_mode = 1'b0;
        expect_none(5, "R10 standard gives same byte");
        oc_bits = 7'h01;
        expect_req(8'h01, "R10 standard remap");
    endtask

    task automatic t_stall;
        oc_bits = 7'h22;
        repeat (3) @(negedge clk);
        check(req_valid && req_data == 8'h22, "R7 presented", req_data, 8'h22);
        oc_bits = 7'h33;
        @(negedge clk);
        oc_bits = 7'h44;
        repeat (3) @(negedge clk);
        check(req_valid && req_data == 8'h22, "R7 held while stalled", req_data, 8'h22);
        expect_req(8'h22, "R8 first");
        expect_req(8'h44, "R8 latest only");
        expect_none(5, "R8 no extra");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!req_valid, "R1 valid low in reset", req_valid, 0);
        rst_n = 1'b1;
        t_reset();
        t_standard();
        t_manual();
        t_mode_back();
        t_stall();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule